// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit linear address into a physical address. It walks a hierarchy of four in-memory tables. Each table is 4096 bytes long and holds 512 eight-byte entries. The walk starts from a root register that names the top table. The unit accepts one request at a time. A request carries the linear address, a write flag and a user-mode flag.

The unit reads one entry per level through a simple memory port. The port has a one-cycle request strobe, and the response comes back any number of cycles later. At every level the unit checks the entry's present, writable and user bits. When the walk ends, the unit raises a one-cycle done pulse. Alongside the pulse it presents either the physical address or a fault code. Addresses whose unused upper bits are not a sign extension are refused before any memory read.

Entry bit positions: bit 0 is present, bit 1 is writable, bit 2 is user-accessible, and bits 51:12 hold the next frame. Fault codes on `faultCode`: 0 means success, 1 means not present, 2 means write-protected, 3 means privilege and 4 means non-canonical.

Top module: `pt_walker`

## Requirements
- R1: `reqReady` is high in idle. It goes low in the cycle after a request is accepted and stays low until `done`. It is high again in the cycle after `done`.
- R2: A request with linear address bits 63:48 not all equal to bit 47 ends with code 4 and a physical address of zero. No memory read is issued for it.
- R3: Each entry read goes to the current table frame (bits 51:12) followed by the 9-bit index and three zero bits. The first read uses frame bits 51:12 of `rootBase`, and each later read uses bits 51:12 of the entry read before it.
- R4: The index for the first read is address bits 47:39. The following reads use bits 38:30, then 29:21, then 20:12.
- R5: A walk with no fault makes exactly four reads. It returns code 0 and a physical address made of the last entry's bits 51:12 followed by address bits 11:0, with bits 63:52 zero. Entry bits 63:52 and 11:3 have no effect.
- R6: An entry with bit 0 clear ends the walk with code 1 and issues no further reads.
- R7: A write request ends with code 2 at the first entry on its path whose bit 1 is clear.
- R8: A user request ends with code 3 at the first entry on its path whose bit 2 is clear. A supervisor request ignores bit 2, and a read request ignores bit 1.
- R9: When one entry breaks several rules, not-present wins over write-protect, and write-protect wins over privilege.
- R10: `done` lasts one cycle. `memReqValid` lasts one cycle, and at most one read is outstanding. On any fault the physical address output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Unit idle, request accepted when both high |
| reqAddr | input | 64 | Linear address to translate |
| reqWrite | input | 1 | Request is a write |
| reqUser | input | 1 | Request is from user mode |
| rootBase | input | 64 | Root table register, frame in bits 51:12 |
| memReqValid | output | 1 | One-cycle entry read strobe |
| memReqAddr | output | 64 | Byte address of the entry to read |
| memRspValid | input | 1 | Entry read data valid |
| memRspData | input | 64 | Entry read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| physAddr | output | 64 | Translated address, valid with done |
| faultCode | output | 3 | Result code, valid with done |

## Verification
The not-present, write-protect and privilege checks all judge the same response word in the same cycle. Their interaction is the point most likely to hide an error. Directed walks feed entries with two or three of the flag bits cleared at once, for write and user requests alike. Random walks clear each flag with a modest probability at every level, so coincident violations also occur at random depths. The bench's reference walk applies the stated priority and predicts the code, the number of reads and every read address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ABSENT   = 3'd1,
    FLT_WRPROT   = 3'd2,
    FLT_PRIV     = 3'd3,
    FLT_NONCANON = 3'd4
  } fault_e;

  typedef struct packed {
    logic   load;
    logic   descend;
    logic   setResult;
    logic   setFault;
    fault_e code;
  } ptwStrobe_t;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VA_BITS    = 48,
  parameter int PA_BITS    = 52,
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ptwStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] rootBase,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              canonical,
  output fault_e            entryCode,
  output logic              isLeaf,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] physAddr,
  output fault_e            faultCode
);
  localparam int FRAME_W     = PA_BITS - PAGE_SHIFT;
  localparam int ENTRY_SHIFT = PAGE_SHIFT - IDX_W;
  localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PAD_W       = ADDR_W - PA_BITS;

  logic [VA_BITS-1:0] vaReg;
  logic               wrReg, usrReg;
  logic [FRAME_W-1:0] baseReg;
  logic [LVL_W-1:0]   lvlReg;
  logic [ADDR_W-1:0]  physReg;
  fault_e             codeReg;

  logic [IDX_W-1:0]   idxTab [LEVELS];
  logic [IDX_W-1:0]   curIdx;
  logic [FRAME_W-1:0] nextFrame;
  logic [ADDR_W-VA_BITS:0] upperBits;
  logic unusedBits;

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idxTab[l] = vaReg[PAGE_SHIFT + IDX_W*l +: IDX_W];
  end

  assign curIdx     = idxTab[lvlReg];
  assign nextFrame  = memRspData[PA_BITS-1:PAGE_SHIFT];
  assign upperBits  = reqAddr[ADDR_W-1:VA_BITS-1];
  assign canonical  = (&upperBits) | ~(|upperBits);
  assign isLeaf     = (lvlReg == '0);
  assign memReqAddr = {{PAD_W{1'b0}}, baseReg, curIdx, {ENTRY_SHIFT{1'b0}}};
  assign physAddr   = physReg;
  assign faultCode  = codeReg;
  assign unusedBits = ^{memRspData[ADDR_W-1:PA_BITS], memRspData[PAGE_SHIFT-1:3],
                        rootBase[ADDR_W-1:PA_BITS], rootBase[PAGE_SHIFT-1:0]};

  always_comb begin
    if (!memRspData[BIT_PRESENT])              entryCode = FLT_ABSENT;
    else if (wrReg && !memRspData[BIT_WRITE])  entryCode = FLT_WRPROT;
    else if (usrReg && !memRspData[BIT_USER])  entryCode = FLT_PRIV;
    else                                       entryCode = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaReg   <= '0;
      wrReg   <= 1'b0;
      usrReg  <= 1'b0;
      baseReg <= '0;
      lvlReg  <= '0;
      physReg <= '0;
      codeReg <= FLT_NONE;
    end else begin
      if (strb.load) begin
        vaReg   <= reqAddr[VA_BITS-1:0];
        wrReg   <= reqWrite;
        usrReg  <= reqUser;
        baseReg <= rootBase[PA_BITS-1:PAGE_SHIFT];
        lvlReg  <= LVL_W'(LEVELS - 1);
        physReg <= '0;
        codeReg <= FLT_NONE;
      end
      if (strb.descend) begin
        baseReg <= nextFrame;
        lvlReg  <= lvlReg - 1'b1;
      end
      if (strb.setResult) begin
        physReg <= {{PAD_W{1'b0}}, nextFrame, vaReg[PAGE_SHIFT-1:0]};
        codeReg <= FLT_NONE;
      end
      if (strb.setFault) begin
        physReg <= '0;
        codeReg <= strb.code;
      end
    end
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       memRspValid,
  input  logic       canonical,
  input  fault_e     entryCode,
  input  logic       isLeaf,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       done,
  output ptwStrobe_t strb
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FINISH} state_e;
  state_e state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.code = FLT_NONE;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        if (!canonical) begin
          strb.setFault = 1'b1;
          strb.code     = FLT_NONCANON;
          nextState     = S_FINISH;
        end else begin
          nextState = S_ISSUE;
        end
      end
      S_ISSUE: nextState = S_WAIT;
      S_WAIT: if (memRspValid) begin
        if (entryCode != FLT_NONE) begin
          strb.setFault = 1'b1;
          strb.code     = entryCode;
          nextState     = S_FINISH;
        end else if (isLeaf) begin
          strb.setResult = 1'b1;
          nextState      = S_FINISH;
        end else begin
          strb.descend = 1'b1;
          nextState    = S_ISSUE;
        end
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign done        = (state == S_FINISH);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_BITS    = 48,
  parameter int PA_BITS    = 52,
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [63:0] reqAddr,
  input  logic        reqWrite,
  input  logic        reqUser,
  input  logic [63:0] rootBase,
  output logic        memReqValid,
  output logic [63:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  output logic        done,
  output logic [63:0] physAddr,
  output logic [2:0]  faultCode
);
  ptwStrobe_t strb;
  logic       canonical, isLeaf;
  fault_e     entryCode, codeOut;

  ptw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .memRspValid(memRspValid),
    .canonical(canonical), .entryCode(entryCode), .isLeaf(isLeaf),
    .reqReady(reqReady), .memReqValid(memReqValid), .done(done), .strb(strb)
  );

  ptw_datapath #(
    .ADDR_W(64), .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .LEVELS(LEVELS),
    .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqUser(reqUser), .rootBase(rootBase), .memRspData(memRspData),
    .canonical(canonical), .entryCode(entryCode), .isLeaf(isLeaf),
    .memReqAddr(memReqAddr), .physAddr(physAddr), .faultCode(codeOut)
  );

  assign faultCode = codeOut;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic        reqReady,
  input logic [63:0] reqAddr,
  input logic        memReqValid,
  input logic        memRspValid,
  input logic        done,
  input logic [63:0] physAddr,
  input logic [2:0]  faultCode
);
  logic [3:0] readCnt;
  logic       badAddr;
  logic       waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readCnt <= '0;
      badAddr <= 1'b0;
      waiting <= 1'b0;
    end else begin
      if (reqValid && reqReady) begin
        readCnt <= '0;
        badAddr <= (reqAddr[63:48] != {16{reqAddr[47]}});
      end else if (memReqValid) begin
        readCnt <= readCnt + 1'b1;
      end
      if (memReqValid)      waiting <= 1'b1;
      else if (memRspValid) waiting <= 1'b0;
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);
  a_r1_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> reqReady);
  a_r2_noncanon_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    done && badAddr |-> faultCode == 3'd4 && readCnt == 4'd0 && physAddr == 64'd0);
  a_r5_four_reads_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    done && faultCode == 3'd0 |-> readCnt == 4'd4);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |=> !memReqValid);
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> !waiting && !reqReady);
  a_r10_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done && faultCode != 3'd0 |-> physAddr == 64'd0);
endmodule

bind pt_walker ptw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .memReqValid(memReqValid), .memRspValid(memRspValid),
  .done(done), .physAddr(physAddr), .faultCode(faultCode)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reqValid = 0, reqWrite = 0, reqUser = 0;
  logic [63:0] reqAddr = '0, rootBase = '0;
  logic        memRspValid = 0;
  logic [63:0] memRspData = '0;
  logic        reqReady, memReqValid, done;
  logic [63:0] memReqAddr, physAddr;
  logic [2:0]  faultCode;

  int tests = 0, fails = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] seenAddr [8];
  int          seenCnt;

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqUser(reqUser), .rootBase(rootBase),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .done(done), .physAddr(physAddr), .faultCode(faultCode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] entryAt(input logic [39:0] frame, input logic [63:0] va, input int lvl);
    logic [8:0] idx;
    idx = va[12 + 9*lvl +: 9];
    return {12'd0, frame, idx, 3'b000};
  endfunction

  // Reference walk (R2..R9)
  task automatic refWalk(input logic [63:0] va, input logic wr, input logic us,
                         output logic [63:0] pa, output logic [2:0] code,
                         output int nrd, output logic [63:0] addrs [4]);
    logic [39:0] frame;
    logic [63:0] e;
    pa = 0; code = 0; nrd = 0;
    for (int i = 0; i < 4; i++) addrs[i] = 0;
    if (va[63:48] != {16{va[47]}}) begin code = 4; return; end
    frame = rootBase[51:12];
    for (int lvl = 3; lvl >= 0; lvl--) begin
      addrs[nrd] = entryAt(frame, va, lvl);
      e = rd(addrs[nrd]);
      nrd++;
      if (!e[0])            begin code = 1; return; end
      if (wr && !e[1])      begin code = 2; return; end
      if (us && !e[2])      begin code = 3; return; end
      frame = e[51:12];
    end
    pa = {12'd0, frame, va[11:0]};
  endtask

  task automatic runWalk(input logic [63:0] va, input logic wr, input logic us, input string tag);
    logic [63:0] ePa, eAddrs [4];
    logic [2:0]  eCode;
    int          eN, lat, cyc;
    logic [63:0] pend;
    refWalk(va, wr, us, ePa, eCode, eN, eAddrs);
    @(negedge clk);
    check({tag, " R1 ready idle"}, {63'd0, reqReady}, 64'd1);
    reqValid = 1; reqAddr = va; reqWrite = wr; reqUser = us;
    @(negedge clk);
    reqValid = 0;
    seenCnt = 0; lat = 0; cyc = 0; pend = 0;
    while (!done && cyc < 200) begin
      if (reqReady) begin
        check({tag, " R1 ready low in walk"}, {63'd0, reqReady}, 64'd0);
      end
      memRspValid = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin memRspValid = 1; memRspData = rd(pend); end
      end else if (memReqValid) begin
        pend = memReqAddr;
        if (seenCnt < 8) seenAddr[seenCnt] = memReqAddr;
        seenCnt++;
        lat = 1 + int'($urandom % 3);
      end
      @(negedge clk);
      cyc++;
    end
    memRspValid = 0;
    if (!done) begin
      tests++; fails++;
      $display("FAIL %s R10 walk timeout actual=no-done expected=done", tag);
      return;
    end
    check({tag, " R2/R6/R7/R8/R9 code"}, {61'd0, faultCode}, {61'd0, eCode});
    check({tag, " R5/R10 physAddr"}, physAddr, ePa);
    check({tag, " R2/R6 read count"}, 64'(seenCnt), 64'(eN));
    for (int i = 0; i < 4; i++)
      if (i < eN && i < seenCnt) check({tag, " R3/R4 entry address"}, seenAddr[i], eAddrs[i]);
    @(negedge clk);
    check({tag, " R1/R10 ready after done"}, {62'd0, reqReady, done}, 64'd2);
  endtask

  // Builds a path for va with per-level flags (3:0 = level 4..1 order index)
  task automatic buildPath(input logic [63:0] va, input logic [2:0] flg [4], input logic randJunk);
    logic [39:0] frame, nxt;
    logic [63:0] e;
    frame = rootBase[51:12];
    for (int lvl = 3; lvl >= 0; lvl--) begin
      nxt = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      e = {12'd0, nxt, 9'd0, flg[3-lvl]};
      if (randJunk) begin
        e[63:52] = 12'($urandom);
        e[11:3]  = 9'($urandom);
      end
      mem[entryAt(frame, va, lvl)] = e;
      frame = nxt;
    end
  endtask

  function automatic logic [63:0] sext(input logic [47:0] v);
    return {{16{v[47]}}, v};
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] flg [4];
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 reset ready", {63'd0, reqReady}, 64'd1);
    check("R10 reset done/memReq", {62'd0, done, memReqValid}, 64'd0);

    rootBase = 64'h0000_0001_2345_6000;
    // Directed: clean path, high canonical address, junk bits (R5, R4, R3)
    mem.delete();
    flg = '{3'b111, 3'b111, 3'b111, 3'b111};
    buildPath(64'hFFFF_FFFF_8100_0ABC, flg, 1);
    runWalk(64'hFFFF_FFFF_8100_0ABC, 1, 1, "dir-R5-ok");
    // Non-canonical (R2)
    runWalk(64'h0001_0000_0000_0000, 0, 0, "dir-R2-noncanon");
    runWalk(64'hFFFF_0000_0000_1000, 1, 1, "dir-R2-noncanon-hi");
    // Not present at top level: nothing built (R6)
    mem.delete();
    runWalk(64'h0000_1234_5678_9000, 0, 0, "dir-R6-top");
    // Not present at leaf with other bits clear too (R6, R9)
    flg = '{3'b111, 3'b111, 3'b111, 3'b000};
    buildPath(64'h0000_7FFF_FFFF_F123, flg, 0);
    runWalk(64'h0000_7FFF_FFFF_F123, 1, 1, "dir-R9-absent-wins");
    // Write-protect wins over privilege (R7, R9)
    mem.delete();
    flg = '{3'b111, 3'b001, 3'b111, 3'b111};
    buildPath(64'h0000_0040_2010_0FFF, flg, 0);
    runWalk(64'h0000_0040_2010_0FFF, 1, 1, "dir-R9-wp-wins");
    // Privilege at level 2 for user read (R8)
    runWalk(64'h0000_0040_2010_0FFF, 0, 1, "dir-R8-priv");
    // Supervisor write through user-clear entry is fine; read through RO fine (R8)
    mem.delete();
    flg = '{3'b011, 3'b011, 3'b011, 3'b011};
    buildPath(64'h0000_5555_AAAA_5000, flg, 0);
    runWalk(64'h0000_5555_AAAA_5000, 1, 0, "dir-R8-super-ok");
    mem.delete();
    flg = '{3'b101, 3'b111, 3'b111, 3'b111};
    buildPath(64'h0000_0000_0000_0000, flg, 0);
    runWalk(64'h0000_0000_0000_0000, 0, 1, "dir-R8-read-ro-ok");
    runWalk(64'h0000_0000_0000_0000, 1, 0, "dir-R7-wp-top");

    // Random walks
    for (int t = 0; t < 400; t++) begin
      logic [63:0] va;
      mem.delete();
      rootBase = {12'd0, 40'({$urandom, $urandom}), 12'd0};
      va = sext(48'({$urandom, $urandom}));
      if ($urandom % 10 == 0) va[63:48] = 16'($urandom);
      for (int l = 0; l < 4; l++) begin
        flg[l][0] = ($urandom % 12) != 0;
        flg[l][1] = ($urandom % 6) != 0;
        flg[l][2] = ($urandom % 6) != 0;
      end
      buildPath(va, flg, 1);
      runWalk(va, 1'($urandom), 1'($urandom), "rand");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule